// File: doc/BRIEF.md
# Packed 10-bit Pixel Unpacker

This block takes a byte stream of packed 10-bit pixels and turns it into one 16-bit word per pixel. Each group on the input is five bytes long and carries four pixels. The first four bytes hold the upper eight bits of each pixel in turn. The fifth byte collects the two low bits of all four pixels. The block holds the four upper-bit bytes until the shared low-bit byte arrives. It then rebuilds the pixels and releases them in order. The low-bit byte is never passed on as a pixel of its own.

Each rebuilt pixel is placed in a 16-bit container word in one of two ways. Right justification puts the pixel in the low ten bits, so the word reads as the plain pixel value. Left justification puts it in the high ten bits with zero padding below it. The mode is taken from an input at the first byte of each line and stays fixed until the next line starts. Line-start and line-end markers travel with the input bytes. A line start always opens a new group. A line end that arrives in the middle of a group raises a sticky misalignment flag.

The output is a valid/ready word stream. A build option replaces it with a byte-serial view that sends the low byte of each word before the high byte. When the consumer stalls, the block holds its pending pixels and pushes back on the input. No input byte is ever lost.

Top module: `raw10_unpacker`

## Requirements
- R1: In a group, pixel k (k = 0..3) is rebuilt as {byte k, bits [2k+1:2k] of byte 4}. Byte 0 is the first byte of the group after a line start. The pixels come out in the order 0, 1, 2, 3.
- R2: When `mode_left_i` = 0 at line start (right justification), the word carries the pixel in bits 9:0 and zeros in bits 15:10.
- R3: When `mode_left_i` = 1 at line start (left justification), the word carries the pixel in bits 15:6 and zeros in bits 5:0.
- R4: Every complete five-byte group gives exactly four output words. The fifth byte never appears as a word of its own.
- R5: The pixels of a group do not come out until its fifth byte has been accepted. `out_valid_o` is high exactly while rebuilt pixels are still waiting to be taken.
- R6: A byte with `in_sol_i` high is always byte 0 of a new group. Any MSB bytes gathered before it are discarded.
- R7: A line end (`in_eol_i` on an accepted byte) anywhere except the fifth byte of a group sets `err_misalign_o`. It also discards the partial group. The flag stays high until reset.
- R8: The justification is sampled from `mode_left_i` on the line-start byte and held for the whole line. Before the first line start it is right justification.
- R9: While `out_valid_o` is high and `out_ready_i` is low, the word stays stable. Input bytes are held back by `in_ready_o` and are not dropped.
- R10: With `BYTE_VIEW` = 1, each word is sent as two bytes on the byte port, low byte first and then high byte. The word port is then tied idle.
- R11: After reset, `out_valid_o` = 0, `err_misalign_o` = 0 and `in_ready_o` = 1.
- R12: An input ramp of 0x000, 0x004, 0x008, ... in right justification comes out as the same ramp of word values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_left_i | input | 1 | Justification request: 0 right, 1 left; sampled at line start |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte accepted when high with valid |
| in_data_i | input | 8 | Packed input byte |
| in_sol_i | input | 1 | Byte is the first of a line |
| in_eol_i | input | 1 | Byte is the last of a line |
| out_valid_o | output | 1 | Output word valid (word view) |
| out_ready_i | input | 1 | Output word taken (word view) |
| out_data_o | output | 16 | Justified pixel word |
| byte_valid_o | output | 1 | Output byte valid (byte view) |
| byte_ready_i | input | 1 | Output byte taken (byte view) |
| byte_data_o | output | 8 | Serialised word byte, low byte first |
| err_misalign_o | output | 1 | Sticky misalignment flag |

## Verification
A group counter that is off by one shows up at the ports within one group. The bench then sees either a word whose value is built from the low-bit byte, or an `out_valid_o` that disagrees with the count of complete pixels it has worked out. Each cycle, the bench compares `out_valid_o` with that count and compares each word taken with its own behavioural decode. A latched mode that is wrong flips the padding of the very next word. A misalignment flag that clears, or that never sets, differs from the bench's own flag on the cycle after the line end.

// File: rtl/raw10_pkg.sv
package raw10_pkg;
  typedef enum logic {
    JUST_RIGHT = 1'b0,
    JUST_LEFT  = 1'b1
  } just_e;
endpackage

// File: rtl/raw10_grp_asm.sv
module raw10_grp_asm
  import raw10_pkg::*;
#(
  parameter int PIX_W = 10,
  parameter int GRP   = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   mode_i,
  input  logic                   in_valid_i,
  output logic                   in_ready_o,
  input  logic [7:0]             in_data_i,
  input  logic                   in_sol_i,
  input  logic                   in_eol_i,
  input  logic                   slot_free_i,
  output logic                   grp_load_o,
  output logic [GRP*PIX_W-1:0]   grp_pix_o,
  output just_e                  grp_mode_o,
  output logic                   err_o
);
  localparam int LSB_W = PIX_W - 8;
  localparam int IDX_W = $clog2(GRP + 1);

  logic [IDX_W-1:0] idx_q, eff_idx;
  logic             last, fire, err_q;
  just_e            line_mode_q;

  // a line start always opens a fresh group
  assign eff_idx    = in_sol_i ? '0 : idx_q;
  assign last       = (eff_idx == IDX_W'(GRP));
  assign in_ready_o = !last || slot_free_i;
  assign fire       = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else if (fire) begin
      if (last || in_eol_i) idx_q <= '0;
      else                  idx_q <= eff_idx + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          err_q <= 1'b0;
    else if (fire && in_eol_i && !last)   err_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 line_mode_q <= JUST_RIGHT;
    else if (fire && in_sol_i)   line_mode_q <= just_e'(mode_i);
  end

  for (genvar k = 0; k < GRP; k++) begin : g_msb
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       byte_q <= '0;
      else if (fire && !last && eff_idx == IDX_W'(k))    byte_q <= in_data_i;
    end
    assign grp_pix_o[k*PIX_W +: PIX_W] = {byte_q, in_data_i[k*LSB_W +: LSB_W]};
  end

  assign grp_load_o = fire && last;
  assign grp_mode_o = line_mode_q;
  assign err_o      = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q) else $error("misalign flag cleared"); // R7

  AST_SOL_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && in_sol_i && !in_eol_i) |=> (idx_q == IDX_W'(1))) else $error("sol did not restart"); // R6
endmodule

// File: rtl/raw10_pix_emit.sv
module raw10_pix_emit
  import raw10_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int CONT_W = 16,
  parameter int GRP    = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [GRP*PIX_W-1:0] pix_i,
  input  just_e                mode_i,
  output logic                 slot_free_o,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [CONT_W-1:0]    out_data_o
);
  localparam int CNT_W = (GRP > 1) ? $clog2(GRP) : 1;
  localparam int PAD_W = CONT_W - PIX_W;

  logic [GRP*PIX_W-1:0] pix_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 valid_q, fire, last;
  just_e                mode_q;
  logic [PIX_W-1:0]     cur;

  assign fire        = valid_q && out_ready_i;
  assign last        = (cnt_q == CNT_W'(GRP - 1));
  assign slot_free_o = !valid_q || (fire && last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
      pix_q   <= '0;
      mode_q  <= JUST_RIGHT;
    end else if (load_i) begin
      valid_q <= 1'b1;
      cnt_q   <= '0;
      pix_q   <= pix_i;
      mode_q  <= mode_i;
    end else if (fire) begin
      if (last) valid_q <= 1'b0;
      else      cnt_q   <= cnt_q + 1'b1;
    end
  end

  always_comb cur = pix_q[cnt_q*PIX_W +: PIX_W];

  assign out_valid_o = valid_q;
  assign out_data_o  = (mode_q == JUST_LEFT) ? {cur, {PAD_W{1'b0}}} : {{PAD_W{1'b0}}, cur};

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o))) else $error("word not held"); // R9

  AST_PAD_RIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && mode_q == JUST_RIGHT) |-> (out_data_o[CONT_W-1:PIX_W] == '0)) else $error("right pad"); // R2

  AST_PAD_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && mode_q == JUST_LEFT) |-> (out_data_o[PAD_W-1:0] == '0)) else $error("left pad"); // R3
endmodule

// File: rtl/raw10_byte_ser.sv
module raw10_byte_ser #(
  parameter int CONT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  input  logic [CONT_W-1:0] word_i,
  output logic              byte_valid_o,
  input  logic              byte_ready_i,
  output logic [7:0]        byte_data_o
);
  localparam int NB   = CONT_W / 8;
  localparam int PH_W = (NB > 1) ? $clog2(NB) : 1;

  logic [CONT_W-1:0] word_q;
  logic [PH_W-1:0]   ph_q;
  logic              valid_q, fire, last;

  assign fire         = valid_q && byte_ready_i;
  assign last         = (ph_q == PH_W'(NB - 1));
  assign word_ready_o = !valid_q || (fire && last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ph_q    <= '0;
      word_q  <= '0;
    end else if (word_valid_i && word_ready_o) begin
      valid_q <= 1'b1;
      ph_q    <= '0;
      word_q  <= word_i;
    end else if (fire) begin
      if (last) valid_q <= 1'b0;
      else      ph_q    <= ph_q + 1'b1;
    end
  end

  // low byte leaves first
  assign byte_valid_o = valid_q;
  assign byte_data_o  = word_q[ph_q*8 +: 8];

  AST_BYTE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && !byte_ready_i) |=> (byte_valid_o && $stable(byte_data_o))) else $error("byte not held"); // R10
endmodule

// File: rtl/raw10_unpacker.sv
module raw10_unpacker
  import raw10_pkg::*;
#(
  parameter int PIX_W     = 10,
  parameter int CONT_W    = 16,
  parameter int GRP       = 4,
  parameter bit BYTE_VIEW = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_left_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [7:0]        in_data_i,
  input  logic              in_sol_i,
  input  logic              in_eol_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [CONT_W-1:0] out_data_o,
  output logic              byte_valid_o,
  input  logic              byte_ready_i,
  output logic [7:0]        byte_data_o,
  output logic              err_misalign_o
);
  logic                 slot_free, grp_load;
  logic [GRP*PIX_W-1:0] grp_pix;
  just_e                grp_mode;
  logic                 w_valid, w_ready;
  logic [CONT_W-1:0]    w_data;

  raw10_grp_asm #(.PIX_W(PIX_W), .GRP(GRP)) u_asm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_left_i),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_data_i   (in_data_i),
    .in_sol_i    (in_sol_i),
    .in_eol_i    (in_eol_i),
    .slot_free_i (slot_free),
    .grp_load_o  (grp_load),
    .grp_pix_o   (grp_pix),
    .grp_mode_o  (grp_mode),
    .err_o       (err_misalign_o)
  );

  raw10_pix_emit #(.PIX_W(PIX_W), .CONT_W(CONT_W), .GRP(GRP)) u_emit (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (grp_load),
    .pix_i       (grp_pix),
    .mode_i      (grp_mode),
    .slot_free_o (slot_free),
    .out_valid_o (w_valid),
    .out_ready_i (w_ready),
    .out_data_o  (w_data)
  );

  if (BYTE_VIEW) begin : g_bytes
    logic unused_word_ready;
    assign unused_word_ready = out_ready_i;
    assign out_valid_o = 1'b0;
    assign out_data_o  = '0;
    raw10_byte_ser #(.CONT_W(CONT_W)) u_ser (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .word_valid_i (w_valid),
      .word_ready_o (w_ready),
      .word_i       (w_data),
      .byte_valid_o (byte_valid_o),
      .byte_ready_i (byte_ready_i),
      .byte_data_o  (byte_data_o)
    );
  end else begin : g_words
    logic unused_byte_ready;
    assign unused_byte_ready = byte_ready_i;
    assign out_valid_o  = w_valid;
    assign out_data_o   = w_data;
    assign w_ready      = out_ready_i;
    assign byte_valid_o = 1'b0;
    assign byte_data_o  = '0;
  end
endmodule

// File: tb/tb_raw10_unpacker.sv
module tb_raw10_unpacker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic mode_left = 1'b0, in_valid = 1'b0, b_in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_sol = 1'b0, in_eol = 1'b0;
  logic in_ready, b_in_ready, out_valid, out_ready, err, b_err;
  logic [15:0] out_data, b_out_data;
  logic b_out_valid, byte_valid, b_byte_valid, b_byte_ready;
  logic [7:0] byte_data, b_byte_data;

  raw10_unpacker dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_left_i(mode_left),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .in_sol_i(in_sol), .in_eol_i(in_eol),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .byte_valid_o(byte_valid), .byte_ready_i(1'b1), .byte_data_o(byte_data),
    .err_misalign_o(err));

  raw10_unpacker #(.BYTE_VIEW(1'b1)) dut_b (
    .clk_i(clk), .rst_ni(rst_n), .mode_left_i(mode_left),
    .in_valid_i(b_in_valid), .in_ready_o(b_in_ready), .in_data_i(in_data),
    .in_sol_i(in_sol), .in_eol_i(in_eol),
    .out_valid_o(b_out_valid), .out_ready_i(1'b1), .out_data_o(b_out_data),
    .byte_valid_o(b_byte_valid), .byte_ready_i(b_byte_ready), .byte_data_o(b_byte_data),
    .err_misalign_o(b_err));

  int n_chk = 0, n_err = 0;
  bit done = 0, rand_ready = 0, model_on = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_idx = 0;
  logic [7:0] m_msb [4];
  bit m_mode = 0, m_err = 0, hold_prev = 0;
  logic [15:0] prev_data;
  logic [15:0] exp_q[$], got_q[$], ref_q[$];
  logic [7:0] b_got[$];

  function automatic logic [15:0] just(input logic [9:0] p, input bit left);
    return left ? {p, 6'b0} : {6'b0, p};
  endfunction

  always @(negedge clk) begin
    out_ready    = rand_ready ? 1'($urandom % 2) : 1'b1;
    b_byte_ready = (($urandom % 3) != 0);
    #1;
    if (rst_n && model_on) begin
      chk(err == m_err, "R7", int'(err), int'(m_err));
      chk(out_valid == (exp_q.size() != 0), "R5", int'(out_valid), int'(exp_q.size() != 0));
      if (hold_prev) chk(out_valid && out_data == prev_data, "R9", int'(out_data), int'(prev_data));
      hold_prev = out_valid && !out_ready;
      prev_data = out_data;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(0, "R4", int'(out_data), 0);
        else begin
          logic [15:0] w;
          w = exp_q.pop_front();
          chk(out_data == w, "R1", int'(out_data), int'(w));
        end
        got_q.push_back(out_data);
      end
      if (in_valid && in_ready) begin
        if (in_sol) begin m_idx = 0; m_mode = mode_left; end
        if (m_idx == 4) begin
          for (int k = 0; k < 4; k++)
            exp_q.push_back(just({m_msb[k], in_data[2*k +: 2]}, m_mode));
          m_idx = 0;
        end else begin
          m_msb[m_idx] = in_data;
          m_idx++;
          if (in_eol) begin m_err = 1; m_idx = 0; end
        end
      end
    end
    if (rst_n && b_byte_valid && b_byte_ready) b_got.push_back(b_byte_data);
  end

  task automatic send_byte(input bit sel, input logic [7:0] d, input bit s, input bit e);
    in_data = d; in_sol = s; in_eol = e;
    if (sel) b_in_valid = 1'b1; else in_valid = 1'b1;
    #2;
    while (!(sel ? b_in_ready : in_ready)) begin @(negedge clk); #2; end
    @(negedge clk);
    in_valid = 1'b0; b_in_valid = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
  endtask

  // one line of ngrp full groups, pixel n = start + n*step
  task automatic send_line(input bit sel, input int ngrp, input int start, input int step,
                           input bit left, input bit flip);
    mode_left = left;
    for (int g = 0; g < ngrp; g++) begin
      logic [9:0] p [4];
      for (int k = 0; k < 4; k++) begin
        p[k] = 10'(start + (g*4 + k)*step);
        ref_q.push_back(just(p[k], left));
      end
      for (int k = 0; k < 4; k++) begin
        send_byte(sel, p[k][9:2], (g == 0 && k == 0), 1'b0);
        if (flip) mode_left = !left;
      end
      send_byte(sel, {p[3][1:0], p[2][1:0], p[1][1:0], p[0][1:0]}, 1'b0, (g == ngrp-1));
    end
  endtask

  task automatic drain_cmp(input string req);
    bit r;
    r = rand_ready;
    rand_ready = 0;
    repeat (12) @(negedge clk);
    chk(got_q.size() == ref_q.size(), req, got_q.size(), ref_q.size());
    for (int i = 0; i < ref_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == ref_q[i], req, int'(got_q[i]), int'(ref_q[i]));
    got_q.delete(); ref_q.delete();
    rand_ready = r;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R11", int'(out_valid), 0);
    chk(err == 0, "R11", int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1, "R11", int'(in_ready), 1);
    chk(out_valid == 0 && err == 0, "R11", int'({out_valid, err}), 0);
    model_on = 1;

    // R12 ramp, right justified
    send_line(0, 3, 0, 4, 0, 0);
    drain_cmp("R12");
    // R3 left justification
    send_line(0, 2, 5, 37, 1, 0);
    drain_cmp("R3");
    // R2 full-range right justification
    send_line(0, 2, 1023, 341, 0, 0);
    drain_cmp("R2");
    // R6 partial group then fresh line start
    mode_left = 0;
    send_byte(0, 8'hEE, 1, 0);
    send_byte(0, 8'hDD, 0, 0);
    send_line(0, 1, 100, 3, 0, 0);
    drain_cmp("R6");
    // R8 mode flips mid-line, line keeps the sampled mode
    send_line(0, 2, 7, 11, 0, 1);
    drain_cmp("R8");
    send_line(0, 1, 9, 13, 1, 1);
    drain_cmp("R8");
    // R4 five bytes yield four words
    send_line(0, 5, 3, 1, 0, 0);
    drain_cmp("R4");

    // R10 byte view on second instance
    mode_left = 0;
    send_byte(1, 8'hFF, 1, 0);
    send_byte(1, 8'h00, 0, 0);
    send_byte(1, 8'h55, 0, 0);
    send_byte(1, 8'hAA, 0, 0);
    send_byte(1, 8'h97, 0, 1);
    repeat (30) @(negedge clk);
    begin
      logic [7:0] eb [8];
      eb = '{8'hFF, 8'h03, 8'h01, 8'h00, 8'h55, 8'h01, 8'hAA, 8'h02};
      chk(b_got.size() == 8, "R10", b_got.size(), 8);
      for (int i = 0; i < 8 && i < b_got.size(); i++)
        chk(b_got[i] == eb[i], "R10", int'(b_got[i]), int'(eb[i]));
      chk(b_out_valid == 0, "R10", int'(b_out_valid), 0);
    end

    // R9 random backpressure
    rand_ready = 1;
    for (int l = 0; l < 40; l++)
      send_line(0, 1 + ($urandom % 6), int'($urandom % 1024), int'($urandom % 64),
                1'($urandom % 2), 1'($urandom % 2));
    drain_cmp("R9");

    // R7 line end inside a group
    mode_left = 0;
    send_byte(0, 8'h11, 1, 0);
    send_byte(0, 8'h22, 0, 0);
    send_byte(0, 8'h33, 0, 1);
    @(negedge clk);
    chk(err == 1, "R7", int'(err), 1);
    send_line(0, 2, 40, 4, 0, 0);
    drain_cmp("R7");
    chk(err == 1, "R7", int'(err), 1);
    chk(exp_q.size() == 0 && out_valid == 0, "R5", int'(out_valid), 0);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule